// File: doc/BRIEF.md
# Single-Shot Converter Request Controller

This block sits between two requesters and one analog-to-digital converter unit. It runs exactly one conversion per accepted request. The two requesters are a software register port and a low-power coprocessor port. Two ownership inputs pick the requester independently for each function: one picks who owns the start trigger, the other picks who owns the channel bitmap. A conversion is launched on the rising edge of the owning start bit. The launch happens only if the controller is idle and the owning bitmap selects exactly one channel.

Once launched, the controller powers the converter as the power mode says. It waits a settle interval when it controls power itself. It then drives the request and the selected channel to the converter until the converter acknowledges with a raw sample. At that point it raises a done flag and holds the formatted result. The result is scaled to the selected width and is optionally inverted. It stays readable until the next accepted start.

Top module: `adc_oneshot_ctrl`

## Requirements
- R1: When `trig_own_sw` is 1 only `sw_start` can launch a conversion; when 0 only `cp_start` can. Edges on the other start input have no effect.
- R2: When `map_own_sw` is 1 the channel bitmap is taken from `sw_chmap`, otherwise from `cp_chmap`, and `cv_chan` presents that bitmap during the conversion.
- R3: A conversion launches only on a 0-to-1 transition of the owning start input; keeping it high launches nothing more.
- R4: A start edge that arrives while `busy` is 1 is dropped, not queued, and `cv_chan` stays unchanged for the whole conversion.
- R5: An owning bitmap with no bit set or with more than one bit set is rejected: `busy` stays 0, no request reaches the converter and `done` keeps its value.
- R6: `cv_req` is 1 only while `busy` is 1, and `cv_chan` is one-hot whenever `cv_req` is 1.
- R7: `done` goes to 0 on the clock edge that accepts a start (with `busy` rising on the same edge). It goes to 1, and `result` is loaded, on the edge where `cv_ack` is seen with `cv_req` high. `result` changes at no other time.
- R8: `width_code` 0, 1, 2, 3 selects a 9, 10, 11, 12-bit result. The result is the raw 12-bit sample shifted right by 3 minus the code, so full scale is 511, 1023, 2047 or 4095.
- R9: With `invert_en` at 1 the result is full scale minus the scaled value.
- R10: `pwr_mode[1]` = 1 puts power under software: `cv_pwr` follows `pwr_mode[0]` (0 off, 1 on) one cycle later and the request is issued on the accepting edge. `pwr_mode[1]` = 0 puts power under the state machine: `cv_pwr` equals `busy`, and `cv_req` rises `SETTLE_CYC` cycles after `busy`.
- R11: After reset `busy`, `done`, `cv_req`, `cv_pwr` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_own_sw | input | 1 | 1: software port owns the start trigger; 0: coprocessor |
| map_own_sw | input | 1 | 1: software port owns the channel bitmap; 0: coprocessor |
| sw_start | input | 1 | Software start bit |
| cp_start | input | 1 | Coprocessor start bit |
| sw_chmap | input | N_CH | Software channel bitmap |
| cp_chmap | input | N_CH | Coprocessor channel bitmap |
| pwr_mode | input | 2 | Power override: bit 1 selects software, bit 0 is the software power level |
| width_code | input | 2 | Result width select, 9 + code bits |
| invert_en | input | 1 | Invert the result within its width |
| cv_req | output | 1 | Conversion request to the converter |
| cv_chan | output | N_CH | One-hot channel select to the converter |
| cv_pwr | output | 1 | Converter power enable |
| cv_ack | input | 1 | Converter completion pulse |
| cv_raw | input | MIN_W+3 | Raw sample, valid with `cv_ack` |
| busy | output | 1 | A measurement is in progress |
| done | output | 1 | Last measurement finished and `result` is valid |
| result | output | MIN_W+3 | Formatted conversion value |

## Verification
A corrupted state register shows at the ports within one cycle. It appears either as `cv_req` without `busy` or as a `cv_pwr` level that disagrees with `busy` under state-machine power. A lost or stale edge detector shows up as a conversion count that differs from the number of accepted edges. The count is visible on the converter side after one conversion latency. A wrong capture of the channel or format shows on the first `done` as a mismatched `cv_chan` or `result`.

// File: rtl/adc1s_pkg.sv
package adc1s_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2
  } adc1s_state_e;
endpackage

// File: rtl/adc1s_src_sel.sv
module adc1s_src_sel #(
  parameter int N_CH = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig_own_sw,
  input  logic            map_own_sw,
  input  logic            sw_start,
  input  logic            cp_start,
  input  logic [N_CH-1:0] sw_chmap,
  input  logic [N_CH-1:0] cp_chmap,
  output logic            start_edge,
  output logic [N_CH-1:0] chmap,
  output logic            map_ok
);
  logic start_sel;
  logic start_prev_q;

  assign start_sel = trig_own_sw ? sw_start : cp_start;

  always_ff @(posedge clk) begin
    if (rst) start_prev_q <= 1'b0;
    else     start_prev_q <= start_sel;
  end

  assign start_edge = start_sel & ~start_prev_q;
  assign chmap      = map_own_sw ? sw_chmap : cp_chmap;
  assign map_ok     = $onehot(chmap);
endmodule

// File: rtl/adc1s_settle_timer.sv
module adc1s_settle_timer #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst, run};
      assign expired   = 1'b1;
    end else begin : g_cnt
      localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
      logic [CW-1:0] cnt_q;
      assign expired = (cnt_q == CW'(SETTLE_CYC - 1));
      always_ff @(posedge clk) begin
        if (rst || !run)   cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/adc1s_fmt.sv
module adc1s_fmt #(
  parameter int MIN_W = 9,
  localparam int RAW_W = MIN_W + 3
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [1:0]       wcode,
  input  logic             inv,
  output logic [RAW_W-1:0] val
);
  logic [1:0]       drop_bits;
  logic [RAW_W-1:0] scaled;
  logic [RAW_W-1:0] span;

  assign drop_bits = 2'd3 - wcode;
  assign scaled    = raw >> drop_bits;
  assign span      = {RAW_W{1'b1}} >> drop_bits;
  assign val       = inv ? (span ^ scaled) : scaled;
endmodule

// File: rtl/adc1s_pwr.sv
module adc1s_pwr (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pwr_mode,
  input  logic       busy_next,
  output logic       cv_pwr
);
  always_ff @(posedge clk) begin
    if (rst)              cv_pwr <= 1'b0;
    else if (pwr_mode[1]) cv_pwr <= pwr_mode[0];
    else                  cv_pwr <= busy_next;
  end
endmodule

// File: rtl/adc_oneshot_ctrl.sv
module adc_oneshot_ctrl
  import adc1s_pkg::*;
#(
  parameter int N_CH       = 10,
  parameter int MIN_W      = 9,
  parameter int SETTLE_CYC = 2,
  localparam int RAW_W     = MIN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_own_sw,
  input  logic             map_own_sw,
  input  logic             sw_start,
  input  logic             cp_start,
  input  logic [N_CH-1:0]  sw_chmap,
  input  logic [N_CH-1:0]  cp_chmap,
  input  logic [1:0]       pwr_mode,
  input  logic [1:0]       width_code,
  input  logic             invert_en,
  output logic             cv_req,
  output logic [N_CH-1:0]  cv_chan,
  output logic             cv_pwr,
  input  logic             cv_ack,
  input  logic [RAW_W-1:0] cv_raw,
  output logic             busy,
  output logic             done,
  output logic [RAW_W-1:0] result
);
  adc1s_state_e     state_q, state_d;
  logic             start_edge;
  logic             map_ok;
  logic [N_CH-1:0]  chmap;
  logic             settle_done;
  logic             accept;
  logic             finish;
  logic [RAW_W-1:0] fmt_val;

  adc1s_src_sel #(.N_CH(N_CH)) u_src (
    .clk(clk), .rst(rst),
    .trig_own_sw(trig_own_sw), .map_own_sw(map_own_sw),
    .sw_start(sw_start), .cp_start(cp_start),
    .sw_chmap(sw_chmap), .cp_chmap(cp_chmap),
    .start_edge(start_edge), .chmap(chmap), .map_ok(map_ok)
  );

  adc1s_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .run(state_q == ST_SETTLE), .expired(settle_done)
  );

  adc1s_fmt #(.MIN_W(MIN_W)) u_fmt (
    .raw(cv_raw), .wcode(width_code), .inv(invert_en), .val(fmt_val)
  );

  adc1s_pwr u_pwr (
    .clk(clk), .rst(rst), .pwr_mode(pwr_mode),
    .busy_next(state_d != ST_IDLE), .cv_pwr(cv_pwr)
  );

  assign accept = (state_q == ST_IDLE) && start_edge && map_ok;
  assign finish = (state_q == ST_CONV) && cv_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (accept)
          state_d = (!pwr_mode[1] && (SETTLE_CYC > 0)) ? ST_SETTLE : ST_CONV;
      ST_SETTLE:
        if (settle_done) state_d = ST_CONV;
      ST_CONV:
        if (cv_ack) state_d = ST_IDLE;
      default:
        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy    <= 1'b0;
      cv_req  <= 1'b0;
      cv_chan <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d != ST_IDLE);
      cv_req  <= (state_d == ST_CONV);
      if (accept) begin
        cv_chan <= chmap;
        done    <= 1'b0;
      end else if (finish) begin
        done    <= 1'b1;
        result  <= fmt_val;
      end
    end
  end
endmodule

// File: rtl/adc_oneshot_ctrl_chk.sv
module adc_oneshot_ctrl_chk #(
  parameter int N_CH  = 10,
  parameter int RAW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       pwr_mode,
  input logic [1:0]       width_code,
  input logic             busy,
  input logic             done,
  input logic             cv_req,
  input logic             cv_ack,
  input logic [N_CH-1:0]  cv_chan,
  input logic             cv_pwr,
  input logic [RAW_W-1:0] result
);
  // R6: request only inside a measurement, on a single channel
  p_req_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    cv_req |-> busy);
  p_chan_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    cv_req |-> $onehot(cv_chan));
  // R4: channel frozen while a measurement runs
  p_chan_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(cv_chan));
  // R7: accepted start clears done
  p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !done);
  // R7: result moves only on a completion handshake
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(cv_ack && cv_req) |-> $stable(result));
  // R8: a fresh result never exceeds its width's full scale
  p_result_range_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (result <= ({RAW_W{1'b1}} >> (2'd3 - $past(width_code)))));
  // R10: state-machine power tracks busy, software power follows its level bit
  p_pwr_fsm_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_mode[1]) |-> (cv_pwr == busy));
  p_pwr_sw_r10: assert property (@(posedge clk) disable iff (rst)
    $past(pwr_mode[1]) |-> (cv_pwr == $past(pwr_mode[0])));
endmodule

bind adc_oneshot_ctrl adc_oneshot_ctrl_chk #(.N_CH(N_CH), .RAW_W(RAW_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_mode(pwr_mode), .width_code(width_code),
  .busy(busy), .done(done), .cv_req(cv_req), .cv_ack(cv_ack),
  .cv_chan(cv_chan), .cv_pwr(cv_pwr), .result(result)
);

// File: tb/adc_oneshot_ctrl_bench.sv
module adc_oneshot_ctrl_bench;
  localparam int N_CH = 10, MIN_W = 9, RAW_W = 12, SETTLE_CYC = 2, CONV_LAT = 3;

  logic clk = 0, rst = 1;
  logic trig_own_sw = 1, map_own_sw = 1, sw_start = 0, cp_start = 0;
  logic [N_CH-1:0] sw_chmap = '0, cp_chmap = '0;
  logic [1:0] pwr_mode = 2'b00, width_code = 2'd3;
  logic invert_en = 0;
  logic cv_req, cv_pwr, busy, done;
  logic [N_CH-1:0] cv_chan;
  logic cv_ack = 0;
  logic [RAW_W-1:0] cv_raw = '0, result;

  int total = 0, bad = 0, conv_count = 0, lat = 0;
  logic [N_CH-1:0] last_chan = '0;
  logic [RAW_W-1:0] model_raw = '0;
  logic [RAW_W-1:0] exp_q[$];
  logic done_prev = 0;

  always #10 clk = ~clk;

  adc_oneshot_ctrl #(.N_CH(N_CH), .MIN_W(MIN_W), .SETTLE_CYC(SETTLE_CYC)) u_adc_oneshot_ctrl (
    .clk(clk), .rst(rst), .trig_own_sw(trig_own_sw), .map_own_sw(map_own_sw),
    .sw_start(sw_start), .cp_start(cp_start), .sw_chmap(sw_chmap), .cp_chmap(cp_chmap),
    .pwr_mode(pwr_mode), .width_code(width_code), .invert_en(invert_en),
    .cv_req(cv_req), .cv_chan(cv_chan), .cv_pwr(cv_pwr), .cv_ack(cv_ack), .cv_raw(cv_raw),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RAW_W-1:0] expv(input logic [RAW_W-1:0] raw, input int w, input bit inv);
    int bits, fs, s;
    bits = MIN_W + w;
    fs = (1 << bits) - 1;
    s = int'(raw) / (1 << (RAW_W - bits));
    return inv ? RAW_W'(fs - s) : RAW_W'(s);
  endfunction

  // behavioural converter
  always @(negedge clk) begin
    if (cv_ack) cv_ack <= 0;
    else if (cv_req) begin
      if (lat == CONV_LAT - 1) begin
        cv_ack <= 1; cv_raw <= model_raw; last_chan <= cv_chan;
        conv_count <= conv_count + 1; lat <= 0;
      end else lat <= lat + 1;
    end else lat <= 0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done && !done_prev) begin
      if (exp_q.size() == 0) chk(0, "R7 done without request", int'(result), 0);
      else begin
        logic [RAW_W-1:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R8 R9 result", int'(result), int'(e));
      end
    end
    done_prev <= done;
  end

  task automatic wait_idle();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic run_conv(input bit own_sw, input bit msw, input logic [N_CH-1:0] map,
                          input logic [RAW_W-1:0] raw, input int w, input bit inv);
    logic [N_CH-1:0] other;
    other = {map[N_CH-2:0], map[N_CH-1]};
    trig_own_sw = own_sw; map_own_sw = msw;
    sw_chmap = msw ? map : other;
    cp_chmap = msw ? other : map;
    model_raw = raw; width_code = 2'(w); invert_en = inv;
    exp_q.push_back(expv(raw, w, inv));
    @(negedge clk);
    if (own_sw) sw_start = 1; else cp_start = 1;
    @(negedge clk);
    sw_start = 0; cp_start = 0;
    chk(busy && !done, "R7 accept clears done", int'({busy, done}), 2);
    wait_idle();
    chk(last_chan == map, "R2 channel", int'(last_chan), int'(map));
  endtask

  task automatic run_pm(input logic [1:0] pm);
    int settle, pwr_bad;
    bit seen;
    settle = 0; pwr_bad = 0; seen = 0;
    pwr_mode = pm; trig_own_sw = 1; map_own_sw = 1; sw_chmap = 10'b0000001000;
    model_raw = 12'h321; width_code = 2'd3; invert_en = 0;
    exp_q.push_back(expv(12'h321, 3, 0));
    @(negedge clk);
    sw_start = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      sw_start = 0;
      if (busy && !cv_req) settle++;
      if (cv_pwr != (pm[1] ? pm[0] : busy)) pwr_bad++;
      if (seen && !busy) break;
      seen = seen | busy;
    end
    chk(pwr_bad == 0, "R10 power level", pwr_bad, 0);
    chk(settle == (pm[1] ? 0 : SETTLE_CYC), "R10 settle cycles", settle, pm[1] ? 0 : SETTLE_CYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R7 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !cv_req && !cv_pwr && result == 0, "R11 reset state",
        int'({busy, done, cv_req, cv_pwr}), 0);

    // R1 / R2 ownership
    run_conv(1, 1, 10'b0000000001, 12'hABC, 3, 0);
    run_conv(0, 0, 10'b0000100000, 12'h7F3, 2, 0);
    run_conv(1, 0, 10'b1000000000, 12'h19E, 1, 1);
    run_conv(0, 1, 10'b0000000100, 12'hC44, 0, 0);

    // R8 / R9 across widths and inversion
    for (int w = 0; w < 4; w++)
      for (int v = 0; v < 2; v++)
        run_conv(1, 1, 10'b0000010000, 12'h5A7, w, v[0]);
    run_conv(1, 1, 10'b0000000010, 12'h000, 0, 1);   // R9 gives 511
    run_conv(1, 1, 10'b0000000010, 12'hFFF, 3, 0);   // R8 gives 4095

    // R1 non-owning start ignored
    trig_own_sw = 1; sw_chmap = 10'b1; cp_chmap = 10'b1; c0 = conv_count;
    @(negedge clk); cp_start = 1;
    repeat (12) @(negedge clk);
    chk(conv_count == c0 && !busy, "R1 other start ignored", conv_count - c0, 0);
    cp_start = 0;

    // R3 held start does not retrigger
    c0 = conv_count; model_raw = 12'h222; width_code = 3; invert_en = 0;
    exp_q.push_back(expv(12'h222, 3, 0));
    @(negedge clk); sw_start = 1;
    wait_idle();
    repeat (15) @(negedge clk);
    chk(conv_count == c0 + 1 && !busy, "R3 held start single launch", conv_count - c0, 1);
    sw_start = 0;

    // R4 edge while busy dropped
    @(negedge clk);
    c0 = conv_count; model_raw = 12'h0F0;
    exp_q.push_back(expv(12'h0F0, 3, 0));
    sw_start = 1;
    @(negedge clk); sw_start = 0;
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(conv_count == c0 + 1 && !busy, "R4 busy edge dropped", conv_count - c0, 1);

    // R5 invalid bitmaps rejected
    for (int k = 0; k < 2; k++) begin
      c0 = conv_count;
      sw_chmap = (k == 0) ? 10'b0 : 10'b0000000011;
      @(negedge clk); sw_start = 1;
      @(negedge clk); sw_start = 0;
      chk(!busy, "R5 bad map no busy", int'(busy), 0);
      repeat (8) @(negedge clk);
      chk(conv_count == c0 && done && !busy, "R5 bad map rejected", conv_count - c0, 0);
    end
    sw_chmap = 10'b1;

    // R10 power modes
    run_pm(2'b10);
    run_pm(2'b11);
    @(negedge clk);
    chk(cv_pwr == 1'b1 && !busy, "R10 idle software on", int'(cv_pwr), 1);
    run_pm(2'b00);
    @(negedge clk);
    chk(cv_pwr == 1'b0, "R10 idle fsm off", int'(cv_pwr), 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule